// File: doc/BRIEF.md
# Sequenced 32x32 Integer Multiplier

This unit multiplies two integer operands for the execute stage of a small processor core. A private three-state sequencer drives it. The main control gives a one-cycle start request together with the two operands, an accumulate value and the operation mode. Nothing more is needed until the unit answers with a one-cycle finish pulse, and that pulse tells the control it may resume issuing instructions.

The operands enter the multiplier array in the cycle the request is accepted. At that edge two aligned 64-bit partial products are registered: the first operand times the low half of the second, and the first operand times the high half of the second. A short multiply returns the low 32 bits of the product, with an optional 32-bit addend. A carry-save stage reduces the low words of both partial products and the addend to two vectors, and one word adder sums them. A long multiply returns the full 64-bit product, with an optional 64-bit addend. It reuses the same carry-save stage and word adder for the low word and then for the high word. The carry out of the low-word sum is stored between those two cycles.

Top module: `mulseq_unit`

## Requirements
- R1: While reset is high and in the first cycle after it, `busy` and `done` are 0 and `result` is all zeros.
- R2: A request is accepted at a rising edge where `start` is 1 and `busy` is 0. Operands, addend and mode are sampled only at that edge, and later changes to those inputs do not affect the result.
- R3: With `long_mode` = 0, `done` is 1 exactly two cycles after the accepting edge. `result[31:0]` equals (op_a × op_b + addend) mod 2^32, and `result[63:32]` is 0. The addend is `acc_in[31:0]` when `acc_en` = 1 and 0 otherwise, and `acc_in[63:32]` is ignored.
- R4: With `long_mode` = 0, `signed_mode` has no effect on `result`.
- R5: With `long_mode` = 1 and `signed_mode` = 0, `done` is 1 exactly three cycles after the accepting edge. `result` equals (op_a × op_b + addend) mod 2^64, where both operands are unsigned and the addend is `acc_in` when `acc_en` = 1 and 0 otherwise.
- R6: With `long_mode` = 1 and `signed_mode` = 1, both operands are taken as two's complement, and `result` is the two's complement product plus the addend, mod 2^64.
- R7: In a long multiply, the carry out of the low-word sum reaches the high word. This holds for carries of 1 and of 2.
- R8: `busy` is 1 in every cycle from the one after the accepting edge up to the one before the finish pulse. It is 0 in the cycle `done` is 1, so a new request may be accepted in that cycle.
- R9: A `start` seen while `busy` is 1 is ignored. It produces no finish pulse and does not change the operation in flight.
- R10: `done` lasts one cycle per accepted request. `result` changes only in a cycle where `done` is 1 and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request pulse, taken when busy is 0 |
| long_mode | input | 1 | 1 = 64-bit product, 0 = low 32 bits |
| signed_mode | input | 1 | 1 = two's complement operands (long multiply) |
| acc_en | input | 1 | 1 = add acc_in to the product |
| op_a | input | W | First operand |
| op_b | input | W | Second operand |
| acc_in | input | 2W | Addend; only the low W bits are used for a short multiply |
| busy | output | 1 | Operation in flight |
| done | output | 1 | One-cycle finish pulse, result valid |
| result | output | 2W | Product, held until the next finish |

## Verification
The bench builds the unit with the default operand width of 32, so its own 64-bit reference model covers the full operand range. At that width, all-ones unsigned operands plus an all-ones addend force a carry of two out of the low word. The most negative signed operand times itself exercises the sign handling of both partial products. Back-to-back requests issued in the finish cycle, and requests made while busy, test the acceptance rule and the sequencer's return to idle.

// File: rtl/mulseq_pkg.sv
package mulseq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOW  = 2'd1,
    ST_HIGH = 2'd2
  } mseq_state_e;
endpackage

// File: rtl/mulseq_ppgen.sv
// Splits op_b into two halves and forms two aligned 2W-bit partial products.
// W must be even and at least 8.
module mulseq_ppgen #(
  parameter int W = 32
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic           sgn,
  output logic [2*W-1:0] pp_lo,
  output logic [2*W-1:0] pp_hi
);
  localparam int H   = W / 2;
  localparam int PW  = W + H + 2;
  localparam int EXT = 2 * W - PW;

  logic signed [W:0]    a_s;
  logic signed [H:0]    bl_s;
  logic signed [H:0]    bh_s;
  logic signed [PW-1:0] p0;
  logic signed [PW-1:0] p1;
  logic [2*W-1:0]       p1_ext;

  assign a_s  = $signed({sgn & a[W-1], a});
  assign bl_s = $signed({1'b0, b[H-1:0]});
  assign bh_s = $signed({sgn & b[W-1], b[W-1:H]});

  assign p0 = a_s * bl_s;
  assign p1 = a_s * bh_s;

  assign pp_lo  = {{EXT{p0[PW-1]}}, p0};
  assign p1_ext = {{EXT{p1[PW-1]}}, p1};
  assign pp_hi  = p1_ext << H;
endmodule

// File: rtl/mulseq_csa.sv
module mulseq_csa #(
  parameter int N = 32
) (
  input  logic [N-1:0] x,
  input  logic [N-1:0] y,
  input  logic [N-1:0] z,
  output logic [N-1:0] s,
  output logic [N-1:0] c
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    assign s[i] = x[i] ^ y[i] ^ z[i];
    assign c[i] = (x[i] & y[i]) | (x[i] & z[i]) | (y[i] & z[i]);
  end
endmodule

// File: rtl/mulseq_wordadd.sv
// Sums a carry-save pair plus a 2-bit carry-in; returns the word and a 2-bit carry out.
module mulseq_wordadd #(
  parameter int N = 32
) (
  input  logic [N-1:0] s,
  input  logic [N-1:0] c,
  input  logic [1:0]   cin,
  output logic [N-1:0] sum,
  output logic [1:0]   cout
);
  logic [N+1:0] total;

  assign total = {2'b00, s} + {1'b0, c, 1'b0} + {{N{1'b0}}, cin};
  assign sum   = total[N-1:0];
  assign cout  = total[N+1:N];
endmodule

// File: rtl/mulseq_unit.sv
module mulseq_unit
  import mulseq_pkg::*;
#(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic           long_mode,
  input  logic           signed_mode,
  input  logic           acc_en,
  input  logic [W-1:0]   op_a,
  input  logic [W-1:0]   op_b,
  input  logic [2*W-1:0] acc_in,
  output logic           busy,
  output logic           done,
  output logic [2*W-1:0] result
);
  localparam int RW = 2 * W;

  mseq_state_e    state;
  logic [RW-1:0]  pp_lo_d, pp_hi_d;
  logic [RW-1:0]  pp_lo_q, pp_hi_q, acc_q;
  logic           long_q;
  logic [W-1:0]   lo_q;
  logic [1:0]     cy_q;
  logic           sel_hi;
  logic [W-1:0]   wx, wy, wz, cs_s, cs_c, wsum;
  logic [1:0]     wcin, wcout;
  logic [RW-1:0]  acc_pick;

  mulseq_ppgen #(.W(W)) i_ppgen (
    .a     (op_a),
    .b     (op_b),
    .sgn   (signed_mode & long_mode),
    .pp_lo (pp_lo_d),
    .pp_hi (pp_hi_d)
  );

  assign acc_pick = !acc_en   ? '0 :
                    long_mode ? acc_in : {{W{1'b0}}, acc_in[W-1:0]};

  // One reduction path shared by the low and high word cycles.
  assign sel_hi = (state == ST_HIGH);
  assign wx     = sel_hi ? pp_lo_q[RW-1:W] : pp_lo_q[W-1:0];
  assign wy     = sel_hi ? pp_hi_q[RW-1:W] : pp_hi_q[W-1:0];
  assign wz     = sel_hi ? acc_q[RW-1:W]   : acc_q[W-1:0];
  assign wcin   = sel_hi ? cy_q : 2'b00;

  mulseq_csa #(.N(W)) i_csa (
    .x (wx),
    .y (wy),
    .z (wz),
    .s (cs_s),
    .c (cs_c)
  );

  mulseq_wordadd #(.N(W)) i_add (
    .s    (cs_s),
    .c    (cs_c),
    .cin  (wcin),
    .sum  (wsum),
    .cout (wcout)
  );

  assign busy = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      done    <= 1'b0;
      result  <= '0;
      pp_lo_q <= '0;
      pp_hi_q <= '0;
      acc_q   <= '0;
      long_q  <= 1'b0;
      lo_q    <= '0;
      cy_q    <= 2'b00;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            pp_lo_q <= pp_lo_d;
            pp_hi_q <= pp_hi_d;
            acc_q   <= acc_pick;
            long_q  <= long_mode;
            state   <= ST_LOW;
          end
        end
        ST_LOW: begin
          if (long_q) begin
            lo_q  <= wsum;
            cy_q  <= wcout;
            state <= ST_HIGH;
          end else begin
            result <= {{W{1'b0}}, wsum};
            done   <= 1'b1;
            state  <= ST_IDLE;
          end
        end
        ST_HIGH: begin
          result <= {wsum, lo_q};
          done   <= 1'b1;
          state  <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mulseq_unit_chk.sv
module mulseq_unit_chk #(
  parameter int W = 32
) (
  input logic           clk,
  input logic           rst,
  input logic           start,
  input logic           long_mode,
  input logic           busy,
  input logic           done,
  input logic [2*W-1:0] result
);
  logic seen_rst;

  always_ff @(posedge clk) begin
    if (rst) seen_rst <= 1'b1;
  end

  p_reset_state_r1: assert property (@(posedge clk) disable iff (rst || seen_rst !== 1'b1)
    $fell(rst) |-> (!busy && !done && result == '0));

  p_busy_on_accept_r2: assert property (@(posedge clk) disable iff (rst || seen_rst !== 1'b1)
    (start && !busy) |=> busy);

  p_short_latency_r3: assert property (@(posedge clk) disable iff (rst || seen_rst !== 1'b1)
    (start && !busy && !long_mode) |=> !done ##1 done);

  p_long_latency_r5: assert property (@(posedge clk) disable iff (rst || seen_rst !== 1'b1)
    (start && !busy && long_mode) |=> !done ##1 !done ##1 done);

  p_idle_at_finish_r8: assert property (@(posedge clk) disable iff (rst || seen_rst !== 1'b1)
    done |-> !busy);

  p_single_pulse_r10: assert property (@(posedge clk) disable iff (rst || seen_rst !== 1'b1)
    done |=> !done);

  p_result_held_r10: assert property (@(posedge clk) disable iff (rst || seen_rst !== 1'b1)
    !done |-> $stable(result));
endmodule

bind mulseq_unit mulseq_unit_chk #(.W(W)) i_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .long_mode (long_mode),
  .busy      (busy),
  .done      (done),
  .result    (result)
);

// File: tb/test_mulseq_unit.sv
module test_mulseq_unit;
  localparam int W = 32;
  localparam int CLK_PERIOD = 10;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic          long_mode = 1'b0;
  logic          signed_mode = 1'b0;
  logic          acc_en = 1'b0;
  logic [31:0]   op_a = '0;
  logic [31:0]   op_b = '0;
  logic [63:0]   acc_in = '0;
  logic          busy;
  logic          done;
  logic [63:0]   result;

  typedef struct packed {
    logic [63:0] val;
    logic [31:0] issue;
    logic [31:0] lat;
    logic [7:0]  req;
  } exp_t;

  exp_t        sb[$];
  int          checks = 0;
  int          errors = 0;
  int          issued = 0;
  int          finished = 0;
  logic [31:0] cyc = '0;
  logic        ended = 1'b0;

  mulseq_unit #(.W(W)) i_mulseq_unit (
    .clk(clk), .rst(rst), .start(start), .long_mode(long_mode),
    .signed_mode(signed_mode), .acc_en(acc_en), .op_a(op_a), .op_b(op_b),
    .acc_in(acc_in), .busy(busy), .done(done), .result(result)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic string reqname(input logic [7:0] r);
    case (r)
      8'd3: return "R3";
      8'd4: return "R4";
      8'd5: return "R5";
      8'd6: return "R6";
      8'd7: return "R7";
      default: return "R2";
    endcase
  endfunction

  function automatic logic [63:0] model(input logic [31:0] a, input logic [31:0] b,
                                        input logic [63:0] acc, input logic lng,
                                        input logic sgn, input logic ae);
    logic [63:0] p, ac;
    ac = ae ? acc : 64'd0;
    if (!lng) begin
      p = {32'd0, a} * {32'd0, b};
      return {32'd0, p[31:0] + ac[31:0]};
    end
    if (sgn) p = {{32{a[31]}}, a} * {{32{b[31]}}, b};
    else     p = {32'd0, a} * {32'd0, b};
    return p + ac;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic [31:0] a, input logic [31:0] b, input logic [63:0] acc,
                       input logic lng, input logic sgn, input logic ae, input logic [7:0] req);
    exp_t e;
    @(negedge clk);
    while (busy) @(negedge clk);
    start = 1'b1; op_a = a; op_b = b; acc_in = acc;
    long_mode = lng; signed_mode = sgn; acc_en = ae;
    e.val = model(a, b, acc, lng, sgn, ae);
    e.issue = cyc; e.lat = lng ? 32'd3 : 32'd2; e.req = req;
    sb.push_back(e);
    issued++;
    @(negedge clk);
    start = 1'b0;
    // R2: scramble inputs after acceptance; the result must not follow them
    op_a = ~a; op_b = b ^ 32'h5A5A_A5A5; acc_in = ~acc;
    long_mode = ~lng; signed_mode = ~sgn; acc_en = ~ae;
    check(busy == 1'b1, "R8", "busy after accept", {63'd0, busy}, 64'd1);
  endtask

  // Scoreboard monitor
  initial begin
    logic        prev_done;
    logic [63:0] last;
    exp_t        e;
    prev_done = 1'b0;
    last = '0;
    @(negedge clk);
    while (rst) @(negedge clk);
    forever begin
      @(negedge clk);
      if (done) begin
        finished++;
        if (busy) check(1'b0, "R8", "busy during done", 64'd1, 64'd0);
        if (prev_done) check(1'b0, "R10", "done longer than one cycle", 64'd1, 64'd0);
        if (sb.size() == 0) begin
          check(1'b0, "R9", "finish with no accepted request", result, 64'd0);
        end else begin
          e = sb.pop_front();
          check(result == e.val, reqname(e.req), "result", result, e.val);
          check(cyc - e.issue == e.lat, reqname(e.req), "latency",
                {32'd0, cyc - e.issue}, {32'd0, e.lat});
        end
        last = result;
      end else if (result !== last) begin
        check(1'b0, "R10", "result changed without done", result, last);
        last = result;
      end
      prev_done = done;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      ended = 1'b1;
      errors++;
      $display("FAIL R10 watchdog: actual hung run, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] x, y;
    logic [63:0] z;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: idle state after reset
    check(busy == 1'b0, "R1", "busy after reset", {63'd0, busy}, 64'd0);
    check(done == 1'b0, "R1", "done after reset", {63'd0, done}, 64'd0);
    check(result == 64'd0, "R1", "result after reset", result, 64'd0);

    // R3: short multiply, with and without addend; high addend word ignored
    issue(32'd7, 32'd9, 64'd0, 1'b0, 1'b0, 1'b0, 8'd3);
    issue(32'h1234_5678, 32'h9ABC_DEF0, 64'hFFFF_FFFF_0000_0011, 1'b0, 1'b0, 1'b1, 8'd3);
    issue(32'hFFFF_FFFF, 32'hFFFF_FFFF, 64'h0000_0000_FFFF_FFFF, 1'b0, 1'b0, 1'b1, 8'd3);
    // R4: signed flag has no effect on a short multiply
    issue(32'h8000_0001, 32'hFFFF_FFFE, 64'd5, 1'b0, 1'b1, 1'b1, 8'd4);
    // R5: unsigned long
    issue(32'hDEAD_BEEF, 32'h0001_0000, 64'd0, 1'b1, 1'b0, 1'b0, 8'd5);
    issue(32'h8765_4321, 32'hFEDC_BA98, 64'h0123_4567_89AB_CDEF, 1'b1, 1'b0, 1'b1, 8'd5);
    // R6: signed long
    issue(32'hFFFF_FFFD, 32'd11, 64'd0, 1'b1, 1'b1, 1'b0, 8'd6);
    issue(32'h8000_0000, 32'h8000_0000, 64'd0, 1'b1, 1'b1, 1'b0, 8'd6);
    issue(32'hFFFF_0000, 32'h8000_7FFF, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b1, 1'b1, 8'd6);
    // R7: low-word carries of 1 and 2 into the high word
    issue(32'hFFFF_FFFF, 32'hFFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b0, 1'b1, 8'd7);
    issue(32'h0000_FFFF, 32'h0001_0001, 64'h0000_0000_FFFF_0001, 1'b1, 1'b0, 1'b1, 8'd7);

    // R9: request made while busy is ignored
    issue(32'd1000, 32'd3000, 64'd77, 1'b1, 1'b0, 1'b1, 8'd5);
    start = 1'b1; op_a = 32'd5; op_b = 32'd6; long_mode = 1'b0;
    @(negedge clk);
    check(busy == 1'b1, "R9", "still busy with ignored start", {63'd0, busy}, 64'd1);
    start = 1'b0;
    while (busy) @(negedge clk);
    repeat (4) @(negedge clk);
    check(finished == issued, "R9", "finish count", finished, issued);

    // R2: mixed traffic, back-to-back where possible
    x = 32'h1357_9BDF; y = 32'h2468_ACE0; z = 64'h0F1E_2D3C_4B5A_6978;
    for (int i = 0; i < 40; i++) begin
      x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
      y = y ^ (y << 7);  y = y ^ (y >> 9);  y = y + x;
      z = {z[62:0], z[63] ^ z[62]} + {x, y};
      issue(x, y, z, y[3], x[5], x[0], y[3] ? (x[5] ? 8'd6 : 8'd5) : 8'd3);
    end
    while (busy || sb.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    check(finished == issued, "R10", "one finish per request", finished, issued);

    if (!ended) begin
      ended = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule